// File: doc/BRIEF.md
# Instruction cycle timing sequencer

This block paces instruction execution in a small 8-bit controller core that runs a reduced number of machine cycles per instruction. When a start strobe comes in with an opcode byte, the sequencer works out the instruction's length in machine cycles and raises `busy` for that length. It pulses `done` in the final clock of the instruction. Every machine cycle is four clocks long. In the first three clocks of each machine cycle the block emits a tick to the peripheral timers, so the peripherals see three ticks per machine cycle.

The length comes from a decode of the opcode. Instructions that move data to or from external memory cost two machine cycles plus a stretch. The stretch is the low three bits of an 8-bit clock-control register, and the core writes that register through a simple write-enable port. The sequencer samples the stretch when an instruction starts.

Top module: `instr_cycle_seq`

## Requirements
- R1: After reset, `busy`, `done` and `periph_tick` are 0 and `clkctl_q` reads 0x01.
- R2: A start strobe accepted while idle raises `busy` from the next clock onward, and `busy` stays high for exactly 4 × N clocks, where N is the instruction's machine-cycle count.
- R3: `done` is high for exactly one clock per instruction: the last clock in which `busy` is high.
- R4: `periph_tick` is high in clocks 0, 1 and 2 of each 4-clock machine cycle, which gives 3 × N ticks per instruction, and it is low whenever the sequencer is idle.
- R5: Cycle counts follow these rules.
  - 1 cycle: register (low nibble 8–F) and indirect (low nibble 6–7) ALU forms, the accumulator-only operations and the carry operations.
  - 2 cycles: immediate and direct ALU forms, the bit operations, push and pop, and the moves between registers and direct or immediate operands.
  - 3 cycles: the short and conditional jumps, the table reads, the pointer load and increment, the direct-to-direct and immediate-to-direct moves, and the logic ops on direct with immediate.
  - 4 cycles: long jump and call, both returns, the bit-test jumps, compare-and-jump (0xB4–0xBF) and decrement-and-jump on a direct operand (0xD5).
  - 3 cycles: decrement-and-jump on a register (0xD8–0xDF).
  - 5 cycles: multiply (0xA4) and divide (0x84).
- R6: Any opcode whose low five bits equal 0x01 or 0x11 (every opcode with low nibble 1) takes 3 cycles.
- R7: External data moves (0xE0, 0xE2, 0xE3, 0xF0, 0xF2, 0xF3) take 2 + `clkctl_q[2:0]` cycles. The upper register bits have no effect.
- R8: A write with `clkctl_we` high updates `clkctl_q` on the next clock. The stretch is taken at start, so a write during an instruction, or in the same clock as its start, only affects later instructions.
- R9: A start strobe while `busy` is high is ignored. The running instruction keeps its length and no second instruction follows.
- R10: Opcode 0xA5 takes 1 cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin timing the opcode on `opcode` |
| opcode | input | 8 | Fetched opcode byte |
| clkctl_we | input | 1 | Write enable for the clock-control register |
| clkctl_wdata | input | 8 | Write data for the clock-control register |
| busy | output | 1 | Instruction in progress |
| done | output | 1 | Final clock of the instruction |
| periph_tick | output | 1 | Peripheral tick, three per machine cycle |
| clkctl_q | output | 8 | Clock-control register value |

## Verification
The assertions check four things on every cycle:
- `busy` only rises after a start strobe.
- `busy` holds until `done`, and drops right after it.
- Ticks appear only while `busy` is high.
- The clock-control register changes only when written.

The assertions cannot check any opcode's actual length, the decode rules, the stretch arithmetic, or whether a write lands before or after an instruction samples it. Only the bench's scenarios show these. The bench sweeps all 256 opcodes, all eight stretch values, and writes and starts injected during an instruction or in the same clock as its start.

// File: rtl/instr_cycle_seq.sv
module instr_cycle_seq #(
  parameter int TICKS     = 3,
  parameter int STRETCH_W = 3,
  parameter logic [7:0] CLKCTL_RST = 8'h01
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic [7:0] opcode,
  input  logic       clkctl_we,
  input  logic [7:0] clkctl_wdata,
  output logic       busy,
  output logic       done,
  output logic       periph_tick,
  output logic [7:0] clkctl_q
);
  localparam int MC_CLKS = TICKS + 1;
  localparam int PH_W    = $clog2(MC_CLKS);
  localparam int MAX_MC  = 2 + (1 << STRETCH_W);
  localparam int CNT_W   = $clog2(MAX_MC + 6);

  logic [PH_W-1:0]  phase;
  logic [CNT_W-1:0] mc_left, total;
  logic [2:0]       base;
  logic             ext;

  always_comb begin
    ext = 1'b0;
    casez (opcode)
      8'b????_0001:                                   base = 3'd3;
      8'h84, 8'hA4:                                   base = 3'd5;
      8'h02, 8'h12, 8'h22, 8'h32, 8'h10, 8'h20, 8'h30,
      8'hD5, 8'b1011_01??, 8'b1011_1???:              base = 3'd4;
      8'h40, 8'h50, 8'h60, 8'h70, 8'h80, 8'h90,
      8'h43, 8'h53, 8'h63, 8'h73, 8'h83, 8'h93, 8'hA3,
      8'h75, 8'h85, 8'b1101_1???:                     base = 3'd3;
      8'h00, 8'h03, 8'h13, 8'h23, 8'h33, 8'h04, 8'h14,
      8'hC4, 8'hD4, 8'hE4, 8'hF4, 8'hB3, 8'hC3, 8'hD3, 8'hA5,
      8'b00??_011?, 8'b00??_1???, 8'b010?_011?, 8'b010?_1???,
      8'b0110_011?, 8'b0110_1???, 8'b1001_011?, 8'b1001_1???,
      8'b11??_011?, 8'b1100_1???, 8'b111?_1???:       base = 3'd1;
      8'hE0, 8'hE2, 8'hE3, 8'hF0, 8'hF2, 8'hF3: begin base = 3'd2; ext = 1'b1; end
      default:                                        base = 3'd2;
    endcase
  end

  assign total = CNT_W'(base) +
                 (ext ? CNT_W'(clkctl_q[STRETCH_W-1:0]) : CNT_W'(0));

  wire last_ph = (phase == PH_W'(MC_CLKS - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      mc_left  <= '0;
      phase    <= '0;
      clkctl_q <= CLKCTL_RST;
    end else begin
      if (clkctl_we) clkctl_q <= clkctl_wdata;
      if (!busy) begin
        if (start) begin
          busy    <= 1'b1;
          mc_left <= total;
          phase   <= '0;
        end
      end else if (last_ph) begin
        phase <= '0;
        if (mc_left == CNT_W'(1)) busy <= 1'b0;
        else mc_left <= mc_left - CNT_W'(1);
      end else begin
        phase <= phase + PH_W'(1);
      end
    end
  end

  assign done        = busy & last_ph & (mc_left == CNT_W'(1));
  assign periph_tick = busy & (phase < PH_W'(TICKS));

  // R2
  busy_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start));
  // R9
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> busy);
  // R3
  done_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy);
  // R4
  tick_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    periph_tick |-> busy);
  // R8
  clkctl_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clkctl_we |=> $stable(clkctl_q));
endmodule

// File: tb/tb_instr_cycle_seq.sv
module tb_instr_cycle_seq;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, clkctl_we = 1'b0;
  logic [7:0] opcode = '0, clkctl_wdata = '0;
  logic busy, done, periph_tick;
  logic [7:0] clkctl_q;
  int n_chk = 0, n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  instr_cycle_seq dut (
    .clk(clk), .rst_n(rst_n), .start(start), .opcode(opcode),
    .clkctl_we(clkctl_we), .clkctl_wdata(clkctl_wdata),
    .busy(busy), .done(done), .periph_tick(periph_tick), .clkctl_q(clkctl_q)
  );

  task automatic check(input string req, input int got, input int exp);
    n_chk++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  function automatic int exp_mc(input logic [7:0] op, input int s);
    int h = int'(op[7:4]);
    case (op[3:0])
      4'h0: exp_mc = (h == 0) ? 1 : (h <= 3) ? 4 : (h <= 9) ? 3 : (h >= 14) ? 2 + s : 2;
      4'h1: exp_mc = 3;
      4'h2: exp_mc = (h <= 3) ? 4 : (h >= 14) ? 2 + s : 2;
      4'h3: exp_mc = (h <= 3) ? 1 : (h <= 10) ? 3 : (h <= 13) ? 1 : 2 + s;
      4'h4: exp_mc = (h == 8 || h == 10) ? 5 : (h == 11) ? 4 :
                     (h <= 1 || h >= 12) ? 1 : 2;
      4'h5: exp_mc = (h == 7 || h == 8) ? 3 : (h == 10) ? 1 :
                     (h == 11 || h == 13) ? 4 : 2;
      4'h6, 4'h7: exp_mc = (h == 7 || h == 8 || h == 10) ? 2 : (h == 11) ? 4 : 1;
      default: exp_mc = (h == 7 || h == 8 || h == 10) ? 2 : (h == 11) ? 4 :
                        (h == 13) ? 3 : 1;
    endcase
  endfunction

  function automatic string req_of(input logic [7:0] op);
    if (op[3:0] == 4'h1) return "R6";
    if (op == 8'hA5) return "R10";
    if (op[7:5] == 3'b111 && (op[3:0] == 4'h0 || op[3:1] == 3'b001)) return "R7";
    return "R5";
  endfunction

  task automatic write_cfg(input logic [7:0] v);
    @(negedge clk); clkctl_we = 1'b1; clkctl_wdata = v;
    @(negedge clk); clkctl_we = 1'b0;
    check("R8", int'(clkctl_q), int'(v));
  endtask

  // kind: 0 none, 1 start at clock inj_at, 2 write at clock inj_at, 3 write with start
  task automatic run(input logic [7:0] op, input int exp, input string req,
                     input int inj_at, input int kind, input logic [7:0] val);
    int cnt = 0, ticks = 0, dn = 0, didx = -1;
    @(negedge clk); start = 1'b1; opcode = op;
    if (kind == 3) begin clkctl_we = 1'b1; clkctl_wdata = val; end
    @(negedge clk); start = 1'b0; clkctl_we = 1'b0;
    while (busy && cnt < 200) begin
      ticks += int'(periph_tick);
      if (done) begin dn++; didx = cnt + 1; end
      cnt++;
      if (cnt == inj_at && kind == 1) begin start = 1'b1; opcode = 8'h00; end
      if (cnt == inj_at && kind == 2) begin clkctl_we = 1'b1; clkctl_wdata = val; end
      @(negedge clk); start = 1'b0; clkctl_we = 1'b0;
    end
    check(req, cnt, exp * 4);
    check("R4", ticks, exp * 3);
    check("R3", dn, 1);
    check("R3", didx, cnt);
    check("R4", int'(periph_tick), 0);
    @(negedge clk);
    check("R9", int'(busy), 0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", int'(busy), 0);
    check("R1", int'(done), 0);
    check("R1", int'(periph_tick), 0);
    check("R1", int'(clkctl_q), 1);

    for (int op = 0; op < 256; op++)
      run(8'(op), exp_mc(8'(op), 1), req_of(8'(op)), -1, 0, 8'h00);

    for (int s = 0; s < 8; s++) begin
      write_cfg(8'(8'hF8 | s));
      run(8'hE0, 2 + s, "R7", -1, 0, 8'h00);
      run(8'hE2, 2 + s, "R7", -1, 0, 8'h00);
      run(8'hE3, 2 + s, "R7", -1, 0, 8'h00);
      run(8'hF0, 2 + s, "R7", -1, 0, 8'h00);
      run(8'hF2, 2 + s, "R7", -1, 0, 8'h00);
      run(8'hF3, 2 + s, "R7", -1, 0, 8'h00);
    end

    write_cfg(8'h02);
    run(8'hE0, 4, "R8", 2, 2, 8'h05);
    check("R8", int'(clkctl_q), 5);
    run(8'hF0, 7, "R8", -1, 0, 8'h00);
    run(8'hE2, 7, "R8", -1, 3, 8'h00);
    check("R8", int'(clkctl_q), 0);
    run(8'hF2, 2, "R8", -1, 0, 8'h00);

    run(8'h84, 5, "R9", 3, 1, 8'h00);
    run(8'hB5, 4, "R9", 15, 1, 8'h00);
    run(8'hA5, 1, "R10", 1, 1, 8'h00);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule